// File: doc/BRIEF.md
# Parallel Lane Sieve Threshold Pipeline

This block adds up logarithmic weights for a running stream of sieve indices and flags the indices whose total is large enough. On each cycle where the caller asserts `in_valid`, a group of `LANES` consecutive indices enters a shift pipeline of accumulators. Index `a` always sits in lane `a mod LANES`. The first accepted group after reset covers indices 0 to `LANES-1`, and each later accepted group starts `LANES` above the previous one. Every accumulator is zeroed as its group enters. The group then moves one stage per clock through `STAGES` injection stages.

Each stage has `NPORT` contribution ports. A port carries a valid bit, a lane number and a `VAL_W`-bit weight, and adds that weight to the chosen lane of the group that sits in that stage during that cycle. An external generator of progression events uses these ports. It must present each weight in exactly the cycle when the target index's group passes the stage, because a one-cycle slip puts the weight on a neighbouring group.

When a group leaves the last stage, each lane's total is compared against the programmable threshold. A lane is reported when its total is strictly greater than the threshold and its second-pass mask bit, captured when the group entered, is set. Reported indices go into a small multi-write FIFO and come out one per cycle, in ascending lane order within a group.

Top module: `lane_sieve_pipe`

## Requirements
- R1: After reset `hit_valid` is 0, and the first accepted group has base index 0. Each cycle with `in_valid`=1 advances the base by LANES (default 4); cycles with `in_valid`=0 do not advance it.
- R2: Lane `l` (0..LANES-1) of a group with base `b` stands for index `b+l`, and a report from that lane shows `hit_index` = `b+l`.
- R3: Accumulators start at zero when their group enters, so weights given to earlier groups never appear in a later group's total.
- R4: Port `p` of stage `j` sits at flat position `j*NPORT+p` of the contribution vectors. Its lane field is the low 2 bits of slice `j*NPORT+p` of `ctb_lane`, and its weight is 8-bit slice `j*NPORT+p` of `ctb_val`. The weight is added to the group accepted `j+1` cycles earlier, meaning the group present at stage `j` in the cycle it is driven.
- R5: All weights given to one lane of one group are summed, including weights from several stages and from both ports of the same stage in the same cycle.
- R6: Accumulators are 10 bits wide and saturate at 1023 instead of wrapping.
- R7: A lane is reported only when its total is strictly greater than `thresh`. A total equal to `thresh` is not reported.
- R8: For a group accepted at clock edge `E`, the first report from that group appears on `hit_valid` in the cycle after edge `E+STAGES+1`, when the FIFO is empty beforehand.
- R9: Hits from one group are reported one per cycle, in ascending lane order, after any reports already queued.
- R10: Bit `l` of `in_mask`, captured when the group enters, must be 1 for lane `l` of that group to be reported. With the bit at 0, the lane is suppressed whatever its total.
- R11: A stage cycle with no group in it produces no report. Weights driven to a stage while it holds no group have no effect.
- R12: The report FIFO holds 8 entries. When a group's hits exceed the free room, the lowest lanes are kept and the rest are dropped. Room freed by the report leaving that same cycle counts as free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new group of LANES indices enters this cycle |
| in_mask | input | LANES | Second-pass pass bits for the entering group, one per lane |
| thresh | input | ACC_W | Report threshold, compared with strict greater-than |
| ctb_valid | input | STAGES*NPORT | Valid bit of each contribution port |
| ctb_lane | input | STAGES*NPORT*log2(LANES) | Target lane of each contribution port |
| ctb_val | input | STAGES*NPORT*VAL_W | Weight of each contribution port |
| hit_valid | output | 1 | A passing index is presented this cycle |
| hit_index | output | IDX_W | Full index of the reported lane |

## Verification
The hardest situation to reach from the ports is a weight arriving in the wrong cycle: one cycle late, to a stage that holds a bubble, or to an accumulator that is already saturated. Each test therefore schedules stimulus by slot number relative to the first entry. Every weight is placed at slot `entry+stage+1`, and a deliberately late weight is checked to land on the following group. A bubble slot between groups shows that the base index does not move and that a weight sent into the empty stage is lost. A run of four back-to-back all-hit groups fills the report FIFO, so the bench can check which lanes are dropped as well as the timing of every report.

// File: rtl/lsieve_pkg.sv
package lsieve_pkg;

   // True when v is a power of two and at least 1.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // Number of bits needed to hold values 0..v.
   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/lsv_inject.sv
// One injection stage: sums the weights aimed at each lane, adds them with
// saturation, and registers the group into the next stage.
module lsv_inject
   import lsieve_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int NPORT    = 2,
   parameter int ACC_W    = 10,
   parameter int VAL_W    = 8,
   parameter int IDX_W    = 32,
   parameter bit USE_MASK = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     up_vld,
   input  logic [IDX_W-1:0]         up_base,
   input  logic [LANES-1:0]         up_mask,
   input  logic [LANES*ACC_W-1:0]   up_acc,
   input  logic [NPORT-1:0]         pv,
   input  logic [NPORT*$clog2(LANES)-1:0] pl,
   input  logic [NPORT*VAL_W-1:0]   pval,
   output logic                     dn_vld,
   output logic [IDX_W-1:0]         dn_base,
   output logic [LANES-1:0]         dn_mask,
   output logic [LANES*ACC_W-1:0]   dn_acc
);
   localparam int LW    = $clog2(LANES);
   localparam int SUM_W = VAL_W + bits_for(NPORT);
   localparam int TW    = ACC_W + SUM_W;
   localparam logic [ACC_W-1:0] ACC_MAX = '1;

   logic [SUM_W-1:0]       psum [LANES];
   logic [LANES*ACC_W-1:0] nxt_acc;

   // Per-lane sum of every port that targets the lane this cycle.
   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         psum[l] = '0;
         for (int p = 0; p < NPORT; p++) begin
            if (pv[p] && (pl[p*LW +: LW] == LW'(l)))
               psum[l] = psum[l] + SUM_W'(pval[p*VAL_W +: VAL_W]);
         end
      end
   end

   // Saturating add per lane.
   generate
      for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
         logic [TW-1:0] tot;
         assign tot = TW'(up_acc[gl*ACC_W +: ACC_W]) + TW'(psum[gl]);
         assign nxt_acc[gl*ACC_W +: ACC_W] =
            (tot > TW'(ACC_MAX)) ? ACC_MAX : tot[ACC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn_vld  <= 1'b0;
         dn_base <= '0;
         dn_acc  <= '0;
      end else begin
         dn_vld  <= up_vld;
         dn_base <= up_base;
         dn_acc  <= up_vld ? nxt_acc : '0;
      end
   end

   generate
      if (USE_MASK) begin : g_mask
         always_ff @(posedge clk) begin
            if (!rst_n) dn_mask <= '0;
            else        dn_mask <= up_mask;
         end
      end else begin : g_nomask
         assign dn_mask = '1;
      end
   endgenerate
endmodule

// File: rtl/lsv_exit_cmp.sv
// Exit comparison: strict greater-than against the threshold, gated by
// the group valid and the second-pass mask.
module lsv_exit_cmp #(
   parameter int LANES = 4,
   parameter int ACC_W = 10
) (
   input  logic                   vld,
   input  logic [LANES-1:0]       mask,
   input  logic [LANES*ACC_W-1:0] acc,
   input  logic [ACC_W-1:0]       thr,
   output logic [LANES-1:0]       hit
);
   generate
      for (genvar gl = 0; gl < LANES; gl++) begin : g_cmp
         assign hit[gl] = vld && mask[gl] && (acc[gl*ACC_W +: ACC_W] > thr);
      end
   endgenerate
endmodule

// File: rtl/lsv_hit_fifo.sv
// Multi-write, single-read report queue. Up to LANES hits enter per cycle
// in ascending lane order; one leaves per cycle. Hits beyond the free room
// (counting the slot freed by this cycle's read) are dropped.
module lsv_hit_fifo
   import lsieve_pkg::*;
#(
   parameter int LANES = 4,
   parameter int IDX_W = 32,
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [LANES-1:0]             hit,
   input  logic [IDX_W-1:0]             base,
   output logic                         out_vld,
   output logic [IDX_W-1:0]             out_idx,
   output logic [bits_for(DEPTH)-1:0]   occ
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = bits_for(DEPTH);
   localparam int RW = bits_for(LANES);

   logic [IDX_W-1:0] mem [DEPTH];
   logic [PW-1:0]    rp, wp;
   logic [CW-1:0]    cnt;
   logic             pop;
   logic [CW-1:0]    room;
   logic [RW-1:0]    rank [LANES];
   logic [LANES-1:0] take;
   logic [RW-1:0]    npush;

   assign pop     = (cnt != '0);
   assign room    = CW'(DEPTH) - cnt + CW'(pop);
   assign out_vld = pop;
   assign out_idx = mem[rp];
   assign occ     = cnt;

   // Rank of each hit among the hits of lower lanes; keep while room lasts.
   always_comb begin
      logic [RW-1:0] run;
      run = '0;
      for (int l = 0; l < LANES; l++) begin
         rank[l] = run;
         take[l] = hit[l] && (int'(run) < int'(room));
         if (hit[l]) run = run + RW'(1);
      end
      npush = '0;
      for (int l = 0; l < LANES; l++)
         if (take[l]) npush = npush + RW'(1);
   end

   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (take[l])
            mem[wp + PW'(rank[l])] <= base + IDX_W'(l);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         rp  <= rp + PW'(pop);
         wp  <= wp + PW'(npush);
         cnt <= cnt - CW'(pop) + CW'(npush);
      end
   end
endmodule

// File: rtl/lane_sieve_pipe.sv
// Parallel lane sieve threshold pipeline (top).
module lane_sieve_pipe
   import lsieve_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int STAGES     = 8,
   parameter int NPORT      = 2,
   parameter int ACC_W      = 10,
   parameter int VAL_W      = 8,
   parameter int IDX_W      = 32,
   parameter int FIFO_DEPTH = 8,
   parameter bit USE_MASK   = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 in_valid,
   input  logic [LANES-1:0]                     in_mask,
   input  logic [ACC_W-1:0]                     thresh,
   input  logic [STAGES*NPORT-1:0]              ctb_valid,
   input  logic [STAGES*NPORT*$clog2(LANES)-1:0] ctb_lane,
   input  logic [STAGES*NPORT*VAL_W-1:0]        ctb_val,
   output logic                                 hit_valid,
   output logic [IDX_W-1:0]                     hit_index
);
   localparam int LW  = $clog2(LANES);
   localparam int AW  = LANES * ACC_W;
   localparam int OCW = bits_for(FIFO_DEPTH);

   // Elaboration-time parameter checks.
   generate
      if (!is_pow2(LANES) || LANES < 2) begin : g_chk_lanes
         $error("lane_sieve_pipe: LANES must be a power of two >= 2");
      end
      if (STAGES < 1 || NPORT < 1) begin : g_chk_stages
         $error("lane_sieve_pipe: STAGES and NPORT must be >= 1");
      end
      if (ACC_W < VAL_W) begin : g_chk_acc
         $error("lane_sieve_pipe: ACC_W must be >= VAL_W");
      end
      if (!is_pow2(FIFO_DEPTH) || FIFO_DEPTH < LANES) begin : g_chk_fifo
         $error("lane_sieve_pipe: FIFO_DEPTH must be a power of two >= LANES");
      end
      if (IDX_W <= LW) begin : g_chk_idx
         $error("lane_sieve_pipe: IDX_W too small");
      end
   endgenerate

   // Stage state: index 0 is the entry register, STAGES is the exit.
   logic             vld_s  [0:STAGES];
   logic [IDX_W-1:0] base_s [0:STAGES];
   logic [LANES-1:0] mask_s [0:STAGES];
   logic [AW-1:0]    acc_s  [0:STAGES];

   // Flattened views for the bound checker.
   logic [STAGES:0]            vld_vec;
   logic [(STAGES+1)*AW-1:0]   acc_flat;
   logic [OCW-1:0]             fifo_occ;

   // Entry: capture group and its base; accumulators start at zero.
   logic             ent_vld;
   logic [IDX_W-1:0] ent_base;
   logic [LANES-1:0] ent_mask;
   logic [IDX_W-1:0] next_base;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_vld   <= 1'b0;
         ent_base  <= '0;
         next_base <= '0;
      end else begin
         ent_vld <= in_valid;
         if (in_valid) begin
            ent_base  <= next_base;
            next_base <= next_base + IDX_W'(LANES);
         end
      end
   end

   generate
      if (USE_MASK) begin : g_ent_mask
         always_ff @(posedge clk) begin
            if (!rst_n)        ent_mask <= '0;
            else if (in_valid) ent_mask <= in_mask;
         end
      end else begin : g_ent_nomask
         assign ent_mask = '1;
      end
   endgenerate

   assign vld_s[0]  = ent_vld;
   assign base_s[0] = ent_base;
   assign mask_s[0] = ent_mask;
   assign acc_s[0]  = '0;

   // Injection stages.
   generate
      for (genvar gj = 0; gj < STAGES; gj++) begin : g_stage
         lsv_inject #(
            .LANES(LANES), .NPORT(NPORT), .ACC_W(ACC_W),
            .VAL_W(VAL_W), .IDX_W(IDX_W), .USE_MASK(USE_MASK)
         ) u_inj (
            .clk    (clk),
            .rst_n  (rst_n),
            .up_vld (vld_s[gj]),
            .up_base(base_s[gj]),
            .up_mask(mask_s[gj]),
            .up_acc (acc_s[gj]),
            .pv     (ctb_valid[gj*NPORT +: NPORT]),
            .pl     (ctb_lane[gj*NPORT*LW +: NPORT*LW]),
            .pval   (ctb_val[gj*NPORT*VAL_W +: NPORT*VAL_W]),
            .dn_vld (vld_s[gj+1]),
            .dn_base(base_s[gj+1]),
            .dn_mask(mask_s[gj+1]),
            .dn_acc (acc_s[gj+1])
         );
      end
      for (genvar gk = 0; gk <= STAGES; gk++) begin : g_flat
         assign vld_vec[gk]              = vld_s[gk];
         assign acc_flat[gk*AW +: AW]    = acc_s[gk];
      end
   endgenerate

   // Exit comparison and report queue.
   logic [LANES-1:0] exit_hit;

   lsv_exit_cmp #(.LANES(LANES), .ACC_W(ACC_W)) u_cmp (
      .vld (vld_s[STAGES]),
      .mask(mask_s[STAGES]),
      .acc (acc_s[STAGES]),
      .thr (thresh),
      .hit (exit_hit)
   );

   lsv_hit_fifo #(.LANES(LANES), .IDX_W(IDX_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (exit_hit),
      .base   (base_s[STAGES]),
      .out_vld(hit_valid),
      .out_idx(hit_index),
      .occ    (fifo_occ)
   );
endmodule

// File: rtl/lane_sieve_pipe_chk.sv
// Property checker attached to every lane_sieve_pipe instance.
module lane_sieve_pipe_chk
   import lsieve_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int STAGES     = 8,
   parameter int NPORT      = 2,
   parameter int ACC_W      = 10,
   parameter int VAL_W      = 8,
   parameter int FIFO_DEPTH = 8
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              hit_valid,
   input logic [STAGES:0]                   vld_vec,
   input logic [(STAGES+1)*LANES*ACC_W-1:0] acc_flat,
   input logic [bits_for(FIFO_DEPTH)-1:0]   fifo_occ
);
   localparam int AW      = LANES * ACC_W;
   localparam int ONE_MAX = NPORT * ((1 << VAL_W) - 1);

   // R1: nothing is reported on the first cycle out of reset.
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !hit_valid);

   // R11: an empty queue and an empty exit stage give no report next cycle.
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_occ == '0 && !vld_vec[STAGES]) |=> !hit_valid);

   // R12: occupancy never passes the queue depth.
   assert_fifo_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fifo_occ) <= FIFO_DEPTH);

   generate
      for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
         // R3: after one stage a fresh group holds no more than one stage of weights.
         assert_fresh_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
            vld_vec[1] |-> (int'(acc_flat[AW + gl*ACC_W +: ACC_W]) <= ONE_MAX));
         for (genvar gk = 1; gk < STAGES; gk++) begin : g_stg
            // R6: totals never fall as a group moves on (no wrap).
            assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
               vld_vec[gk] |=> (vld_vec[gk+1] &&
                  acc_flat[(gk+1)*AW + gl*ACC_W +: ACC_W] >=
                  $past(acc_flat[gk*AW + gl*ACC_W +: ACC_W])));
         end
      end
   endgenerate
endmodule

bind lane_sieve_pipe lane_sieve_pipe_chk #(
   .LANES(LANES), .STAGES(STAGES), .NPORT(NPORT),
   .ACC_W(ACC_W), .VAL_W(VAL_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hit_valid(hit_valid),
   .vld_vec  (vld_vec),
   .acc_flat (acc_flat),
   .fifo_occ (fifo_occ)
);

// File: tb/tb_lane_sieve_pipe.sv
`timescale 1ns/1ps
module tb_lane_sieve_pipe;
   localparam int LANES = 4, STAGES = 8, NPORT = 2, ACC_W = 10, VAL_W = 8, IDX_W = 32;
   localparam int NPT = STAGES * NPORT;
   localparam int LW  = 2;
   localparam int NS  = 48;
   localparam int PER = 20;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  in_valid = 1'b0;
   logic [LANES-1:0]      in_mask = '0;
   logic [ACC_W-1:0]      thresh = '0;
   logic [NPT-1:0]        ctb_valid = '0;
   logic [NPT*LW-1:0]     ctb_lane = '0;
   logic [NPT*VAL_W-1:0]  ctb_val = '0;
   logic                  hit_valid;
   logic [IDX_W-1:0]      hit_index;

   lane_sieve_pipe dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mask(in_mask),
      .thresh(thresh), .ctb_valid(ctb_valid), .ctb_lane(ctb_lane),
      .ctb_val(ctb_val), .hit_valid(hit_valid), .hit_index(hit_index)
   );

   always #(PER/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // Per-slot stimulus schedule.
   bit              s_in   [NS];
   logic [3:0]      s_mask [NS];
   bit              s_cv   [NS][NPT];
   logic [LW-1:0]   s_cl   [NS][NPT];
   logic [VAL_W-1:0] s_cval [NS][NPT];

   // Expected and observed reports.
   int  e_idx [64];
   int  e_slot[64];
   int  ne;
   int  log_idx[64];
   time log_t [64];
   int  nlog = 0;
   time t0;

   always @(negedge clk) begin
      if (rst_n && hit_valid && nlog < 64) begin
         log_idx[nlog] = int'(hit_index);
         log_t[nlog]   = $time;
         nlog++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_sched();
      for (int s = 0; s < NS; s++) begin
         s_in[s] = 1'b0;
         s_mask[s] = 4'hF;
         for (int k = 0; k < NPT; k++) begin
            s_cv[s][k] = 1'b0; s_cl[s][k] = '0; s_cval[s][k] = '0;
         end
      end
      ne = 0;
   endtask

   task automatic add_group(input int slot, input logic [3:0] m);
      s_in[slot] = 1'b1;
      s_mask[slot] = m;
   endtask

   // Weight for the group entered at slot ent, at the given stage and port.
   task automatic add_ctb(input int ent, input int stage, input int port,
                          input int lane, input int val);
      int s, k;
      s = ent + stage + 1;
      k = stage * NPORT + port;
      s_cv[s][k] = 1'b1;
      s_cl[s][k] = LW'(lane);
      s_cval[s][k] = VAL_W'(val);
   endtask

   task automatic add_exp(input int idx, input int slot);
      e_idx[ne] = idx; e_slot[ne] = slot; ne++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; ctb_valid = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      nlog = 0;
   endtask

   task automatic run_sched();
      for (int c = 0; c < NS; c++) begin
         @(negedge clk);
         if (c == 0) t0 = $time;
         in_valid = s_in[c];
         in_mask  = s_mask[c];
         for (int k = 0; k < NPT; k++) begin
            ctb_valid[k] = s_cv[c][k];
            ctb_lane[k*LW +: LW] = s_cl[c][k];
            ctb_val[k*VAL_W +: VAL_W] = s_cval[c][k];
         end
      end
   endtask

   task automatic check_log(input string req);
      chk(nlog == ne, req, "report count", nlog, ne);
      for (int i = 0; i < ne && i < nlog; i++) begin
         chk(log_idx[i] == e_idx[i], req, "index", log_idx[i], e_idx[i]);
         chk(log_t[i] == t0 + time'(e_slot[i] * PER), req, "report time",
             longint'(log_t[i] - t0), longint'(e_slot[i] * PER));
      end
   endtask

   // R1: quiet after reset.
   task automatic t_reset();
      do_reset();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(hit_valid == 1'b0, "R1", "hit_valid after reset", hit_valid, 0);
      end
   endtask

   // R2 R4 R5 R7 R8 R9 R1: basic sums, equality, lane order, base step.
   task automatic t_basic();
      do_reset(); clear_sched(); thresh = 10'd20;
      add_group(0, 4'hF);
      add_ctb(0, 2, 0, 1, 15);
      add_ctb(0, 5, 0, 1, 10);     // R5: 25 > 20
      add_ctb(0, 4, 0, 2, 20);     // R7: equal, no report
      add_ctb(0, 7, 0, 3, 21);     // last stage still counts
      add_group(1, 4'hF);
      add_ctb(1, 0, 1, 0, 30);     // R1: second group base 4
      add_exp(1, 10); add_exp(3, 11); add_exp(4, 12);
      run_sched();
      check_log("R2_R4_R5_R7_R8_R9");
   endtask

   // R3 R4 R11: late weight slides to next group; bubbles are inert.
   task automatic t_timing();
      do_reset(); clear_sched(); thresh = 10'd40;
      add_group(0, 4'hF);
      add_group(1, 4'hF);
      add_group(2, 4'hF);          // R3: no weights, must not report
      add_group(5, 4'hF);          // slot 3,4 bubbles
      add_ctb(0, 3, 0, 0, 50);     // group 0 lane 0
      add_ctb(1, 3, 0, 0, 50);     // one slot late for group 0: lands on group 1
      add_ctb(3, 0, 0, 2, 99);     // R11: stage 0 empty in that slot
      add_ctb(5, 0, 0, 1, 50);     // base 12 -> index 13
      add_exp(0, 10); add_exp(4, 11); add_exp(13, 15);
      run_sched();
      check_log("R3_R4_R11");
   endtask

   // R6: saturation.
   task automatic t_sat();
      do_reset(); clear_sched(); thresh = 10'd1022;
      add_group(0, 4'hF);
      for (int j = 0; j < STAGES; j++) add_ctb(0, j, 0, 2, 255);
      for (int j = 0; j < 4; j++)      add_ctb(0, j, 1, 0, 255);
      add_exp(2, 10);
      run_sched();
      check_log("R6");
   endtask

   // R10: second-pass mask.
   task automatic t_mask();
      do_reset(); clear_sched(); thresh = 10'd5;
      add_group(0, 4'b1010);
      add_ctb(0, 0, 0, 0, 10); add_ctb(0, 0, 1, 1, 10);
      add_ctb(0, 1, 0, 2, 10); add_ctb(0, 1, 1, 3, 10);
      add_exp(1, 10); add_exp(3, 11);
      run_sched();
      check_log("R10");
   endtask

   // R12: queue overflow keeps the lowest lanes.
   task automatic t_overflow();
      do_reset(); clear_sched(); thresh = 10'd5;
      for (int g = 0; g < 4; g++) begin
         add_group(g, 4'hF);
         add_ctb(g, 0, 0, 0, 10); add_ctb(g, 0, 1, 1, 10);
         add_ctb(g, 1, 0, 2, 10); add_ctb(g, 1, 1, 3, 10);
      end
      for (int i = 0; i < 8; i++) add_exp(i, 10 + i);
      add_exp(8, 18); add_exp(9, 19); add_exp(12, 20);
      run_sched();
      check_log("R12");
   endtask

   // R5: two ports of one stage on one lane in the same cycle.
   task automatic t_sameport();
      do_reset(); clear_sched(); thresh = 10'd10;
      add_group(0, 4'hF);
      add_ctb(0, 4, 0, 0, 6); add_ctb(0, 4, 1, 0, 6);
      add_exp(0, 10);
      run_sched();
      check_log("R5");
   endtask

   initial begin
      t_reset();
      t_basic();
      t_timing();
      t_sat();
      t_mask();
      t_overflow();
      t_sameport();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * PER);
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule